// File: doc/BRIEF.md
# Audio Interface Global Control and Status Registers

This block holds the global control and status section of a bus-attached audio interface. A host reaches it through a quadlet-wide slave port. The port carries three kinds of request: quadlet read, quadlet write, and a 64-bit compare/swap. The block keeps the following state:

- a 64-bit owner address
- the most recent event word
- the sample clock selection
- the streaming enable
- the current-source status
- a per-source word that holds live lock bits and sticky slip flags

A host claims the device by swapping its own address into the owner register. Only a compare/swap can change that register. From then on the block pushes event words to the owner through a notification request port. The request carries the owner address and the event word, and it is held until the consumer accepts it. A bus reset releases ownership, stops streaming and drops any pending notification.

Events come from these sources:

- receive configuration changes, on `cfg_chg_i` bit 0
- transmit configuration changes, on `cfg_chg_i` bit 1
- a change of the current-source lock
- completion of a clock-select write
- a change in any source's lock bit

Events that arrive while a notification is still waiting are merged and delivered together in the next one.

Top module: `audio_glob_regs`

## Requirements
- R1: The owner register is 64 bits. Its reset and released value is 0xFFFF000000000000. A read of address 0 returns bits 63:32 and a read of address 1 returns bits 31:0. Quadlet writes to either address are ignored.
- R2: A compare/swap at address 0 returns the old owner value in rsp_data_o[63:0]. It loads the swap operand only when the old value equals the compare operand.
- R3: A bus_reset_i pulse has three effects: the owner returns to 0xFFFF000000000000, the streaming enable clears, and any pending notification is dropped.
- R4: The event register at address 2 holds only the bits of the most recent cycle that had any event. The bit positions are: receive config 0, transmit config 1, current-lock change 4, clock-select accepted 5, any-source lock change 6.
- R5: On an event, ntf_valid_o rises with ntf_word_o set to the event bits and ntf_addr_o set to the owner. Both are held until ntf_ready_i. Events that arrive while a notification is pending are ORed into the next notification word.
- R6: No notification is issued while the owner holds the no-owner value.
- R7: Address 3 is clock select: source in bits 7:0 (0..12), rate in bits 15:8 (0..10). The reset value is 0x020C. A write with an out-of-range field leaves the register unchanged. Every write to address 3 raises event bit 5 on the cycle after the write.
- R8: Address 4 is the streaming enable. A nonzero write sets it, a zero write clears it, and it drives stream_en_o. A read returns it in bit 0.
- R9: Address 5 is status: current-source lock in bit 0 and the nominal rate code in bits 15:8. Writes to it are ignored.
- R10: Address 6 reports each source's lock state in bits 0..10, and any change of those bits raises event bit 6.
- R11: Bits 16..26 of address 6 are per-source slip flags. Each flag stays set until a quadlet read of address 6. That read returns the flags and then clears them. Slips never raise an event.
- R12: Every request gets rsp_valid_o one cycle later. Read data is in bits 31:0, and a read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset pulse |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 read, 1 write, 2 compare/swap |
| req_addr_i | input | 4 | Quadlet address |
| req_wdata_i | input | 32 | Write data |
| req_cmp_i | input | 64 | Compare operand |
| req_swap_i | input | 64 | Swap operand |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 64 | Read data or old owner value |
| cfg_chg_i | input | 2 | Receive/transmit config change pulses |
| src_lock_i | input | 11 | Per-source lock levels |
| src_slip_i | input | 11 | Per-source slip pulses |
| cur_lock_i | input | 1 | Current source locked |
| nom_rate_i | input | 8 | Nominal rate code |
| clk_src_o | output | 8 | Selected clock source |
| clk_rate_o | output | 8 | Selected rate code |
| stream_en_o | output | 1 | Streaming enable |
| ntf_valid_o | output | 1 | Notification request |
| ntf_ready_i | input | 1 | Notification accepted |
| ntf_addr_o | output | 64 | Destination (owner) address |
| ntf_word_o | output | 32 | Event word |

## Verification
The hardest state to reach is a notification that is held back while new events pile up behind it. The bench claims ownership first and keeps ntf_ready_i low. It then fires a second event source while the first word is still presented, and checks that the presented word stays the same. Only then does it pulse ready and check that the merged word appears. A second hard case is a bus reset that lands on a pending request: it must be dropped and ownership must be released. That case is reached the same way, by holding ready low before the reset pulse.

// File: rtl/agrb_pkg.sv
package agrb_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_CAS = 2'd2
  } op_e;

  localparam logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000;

  // event word bit positions (decoded by the owner's software)
  localparam int EV_RXCFG = 0;
  localparam int EV_TXCFG = 1;
  localparam int EV_CURLK = 4;
  localparam int EV_CLKOK = 5;
  localparam int EV_EXTLK = 6;

  localparam int EVW = 32;
endpackage

// File: rtl/agr_owner.sv
module agr_owner
  import agrb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_i,
  input  logic        cas_i,
  input  logic [63:0] cmp_i,
  input  logic [63:0] swp_i,
  output logic [63:0] owner_o,
  output logic        owned_o
);
  logic [63:0] owner_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      owner_q <= NO_OWNER;
    else if (cas_i && (owner_q == cmp_i))
      owner_q <= swp_i;
  end

  assign owner_o = owner_q;
  assign owned_o = (owner_q != NO_OWNER);

  // R2: owner only moves after a compare/swap, a bus reset or a reset
  a_r2_cas_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(owner_q) |-> $past(cas_i || clr_i || rst));

  // R3: bus reset releases ownership
  a_r3_bus_release: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (owner_q == NO_OWNER));
endmodule

// File: rtl/agr_lockstat.sv
module agr_lockstat #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] lock_i,
  input  logic [NSRC-1:0] slip_i,
  input  logic            cur_lock_i,
  input  logic [7:0]      rate_i,
  input  logic            rd_clr_i,
  output logic [NSRC-1:0] lock_o,
  output logic [NSRC-1:0] slip_o,
  output logic            cur_lock_o,
  output logic [7:0]      rate_o,
  output logic            any_chg_o,
  output logic            cur_chg_o
);
  logic [NSRC-1:0] lock_q;
  logic [NSRC-1:0] slip_q;
  logic            cur_q;
  logic [7:0]      rate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
      cur_q  <= 1'b0;
      rate_q <= '0;
    end else begin
      lock_q <= lock_i;
      cur_q  <= cur_lock_i;
      rate_q <= rate_i;
    end
  end

  // sticky slips; a slip arriving in the clearing cycle survives
  always_ff @(posedge clk) begin
    if (rst)
      slip_q <= '0;
    else if (rd_clr_i)
      slip_q <= slip_i;
    else
      slip_q <= slip_q | slip_i;
  end

  assign any_chg_o  = |(lock_i ^ lock_q);
  assign cur_chg_o  = cur_lock_i ^ cur_q;
  assign lock_o     = lock_q;
  assign slip_o     = slip_q;
  assign cur_lock_o = cur_q;
  assign rate_o     = rate_q;

  // R11: no slip flag drops without a clearing read
  a_r11_slip_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_clr_i |=> ((slip_q & $past(slip_q)) == $past(slip_q)));

  // R11: a clearing read keeps only slips of that same cycle
  a_r11_read_clear: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i |=> (slip_q == $past(slip_i)));

  // R10: lock bits follow the inputs one cycle later
  a_r10_lock_track: assert property (@(posedge clk) disable iff (rst)
    !any_chg_o |=> $stable(lock_q));
endmodule

// File: rtl/agr_notify.sv
module agr_notify
  import agrb_pkg::*;
#(
  parameter int EW = EVW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic [EW-1:0] evt_i,
  input  logic          owned_i,
  input  logic [63:0]   owner_i,
  input  logic          ready_i,
  output logic [EW-1:0] note_o,
  output logic          valid_o,
  output logic [EW-1:0] word_o,
  output logic [63:0]   addr_o
);
  logic [EW-1:0] note_q;
  logic [EW-1:0] acc_q;
  logic [EW-1:0] word_q;
  logic [63:0]   addr_q;
  logic          valid_q;
  logic [EW-1:0] merged;

  assign merged = acc_q | evt_i;

  always_ff @(posedge clk) begin
    if (rst)
      note_q <= '0;
    else if (|evt_i)
      note_q <= evt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      acc_q   <= '0;
      word_q  <= '0;
      addr_q  <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
      acc_q   <= '0;
    end else if (valid_q && !ready_i) begin
      if (owned_i)
        acc_q <= merged;
    end else begin
      acc_q <= '0;
      if (owned_i && (|merged)) begin
        valid_q <= 1'b1;
        word_q  <= merged;
        addr_q  <= owner_i;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign note_o  = note_q;
  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign addr_o  = addr_q;

  // R5: a presented request is held until accepted
  a_r5_hold: assert property (@(posedge clk) disable iff (rst || flush_i)
    (valid_q && !ready_i) |=> (valid_q && $stable(word_q) && $stable(addr_q)));

  // R6: a request only starts while an owner is present
  a_r6_owned_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(owned_i));

  // R5: a presented word is never empty
  a_r5_nonempty: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (word_q != '0));
endmodule

// File: rtl/audio_glob_regs.sv
module audio_glob_regs
  import agrb_pkg::*;
#(
  parameter int NSRC     = 11,
  parameter int AW       = 4,
  parameter int SLIP_LSB = 16,
  parameter int SRC_MAX  = 12,
  parameter int RATE_MAX = 10,
  parameter int RST_SRC  = 12,
  parameter int RST_RATE = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_reset_i,
  input  logic            req_valid_i,
  input  logic [1:0]      req_op_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [31:0]     req_wdata_i,
  input  logic [63:0]     req_cmp_i,
  input  logic [63:0]     req_swap_i,
  output logic            rsp_valid_o,
  output logic [63:0]     rsp_data_o,
  input  logic [1:0]      cfg_chg_i,
  input  logic [NSRC-1:0] src_lock_i,
  input  logic [NSRC-1:0] src_slip_i,
  input  logic            cur_lock_i,
  input  logic [7:0]      nom_rate_i,
  output logic [7:0]      clk_src_o,
  output logic [7:0]      clk_rate_o,
  output logic            stream_en_o,
  output logic            ntf_valid_o,
  input  logic            ntf_ready_i,
  output logic [63:0]     ntf_addr_o,
  output logic [31:0]     ntf_word_o
);
  localparam logic [AW-1:0] A_OWN_HI = AW'(0);
  localparam logic [AW-1:0] A_OWN_LO = AW'(1);
  localparam logic [AW-1:0] A_NOTE   = AW'(2);
  localparam logic [AW-1:0] A_CLKSEL = AW'(3);
  localparam logic [AW-1:0] A_ENABLE = AW'(4);
  localparam logic [AW-1:0] A_STATUS = AW'(5);
  localparam logic [AW-1:0] A_EXTST  = AW'(6);
  localparam logic [7:0]    SRC_LIM  = 8'(SRC_MAX);
  localparam logic [7:0]    RATE_LIM = 8'(RATE_MAX);

  op_e op;
  assign op = op_e'(req_op_i);

  logic is_rd, is_wr, is_cas;
  assign is_rd  = req_valid_i && (op == OP_RD);
  assign is_wr  = req_valid_i && (op == OP_WR);
  assign is_cas = req_valid_i && (op == OP_CAS) && (req_addr_i == A_OWN_HI);

  logic wr_sel, wr_en, rd_ext;
  assign wr_sel = is_wr && (req_addr_i == A_CLKSEL);
  assign wr_en  = is_wr && (req_addr_i == A_ENABLE);
  assign rd_ext = is_rd && (req_addr_i == A_EXTST);

  // owner
  logic [63:0] owner;
  logic        owned;
  agr_owner u_owner (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (bus_reset_i),
    .cas_i   (is_cas),
    .cmp_i   (req_cmp_i),
    .swp_i   (req_swap_i),
    .owner_o (owner),
    .owned_o (owned)
  );

  // lock, slip and status capture
  logic [NSRC-1:0] lock_v, slip_v;
  logic            cur_v, any_chg, cur_chg;
  logic [7:0]      rate_v;
  agr_lockstat #(.NSRC(NSRC)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .lock_i     (src_lock_i),
    .slip_i     (src_slip_i),
    .cur_lock_i (cur_lock_i),
    .rate_i     (nom_rate_i),
    .rd_clr_i   (rd_ext),
    .lock_o     (lock_v),
    .slip_o     (slip_v),
    .cur_lock_o (cur_v),
    .rate_o     (rate_v),
    .any_chg_o  (any_chg),
    .cur_chg_o  (cur_chg)
  );

  // clock select
  logic [7:0] src_q, rate_q;
  logic       accept_q;
  logic       sel_ok;
  assign sel_ok = (req_wdata_i[7:0] <= SRC_LIM) && (req_wdata_i[15:8] <= RATE_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= 8'(RST_SRC);
      rate_q   <= 8'(RST_RATE);
      accept_q <= 1'b0;
    end else begin
      accept_q <= wr_sel;
      if (wr_sel && sel_ok) begin
        src_q  <= req_wdata_i[7:0];
        rate_q <= req_wdata_i[15:8];
      end
    end
  end

  // streaming enable
  logic en_q;
  always_ff @(posedge clk) begin
    if (rst || bus_reset_i)
      en_q <= 1'b0;
    else if (wr_en)
      en_q <= |req_wdata_i;
  end

  // event word
  logic [EVW-1:0] evt;
  always_comb begin
    evt           = '0;
    evt[EV_RXCFG] = cfg_chg_i[0];
    evt[EV_TXCFG] = cfg_chg_i[1];
    evt[EV_CURLK] = cur_chg;
    evt[EV_CLKOK] = accept_q;
    evt[EV_EXTLK] = any_chg;
  end

  logic [EVW-1:0] note;
  agr_notify #(.EW(EVW)) u_ntf (
    .clk     (clk),
    .rst     (rst),
    .flush_i (bus_reset_i),
    .evt_i   (evt),
    .owned_i (owned),
    .owner_i (owner),
    .ready_i (ntf_ready_i),
    .note_o  (note),
    .valid_o (ntf_valid_o),
    .word_o  (ntf_word_o),
    .addr_o  (ntf_addr_o)
  );

  // extended status layout
  logic [31:0] ext_word;
  always_comb begin
    ext_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      ext_word[i]            = lock_v[i];
      ext_word[SLIP_LSB + i] = slip_v[i];
    end
  end

  // read mux
  logic [31:0] rd_word;
  always_comb begin
    case (req_addr_i)
      A_OWN_HI: rd_word = owner[63:32];
      A_OWN_LO: rd_word = owner[31:0];
      A_NOTE:   rd_word = note;
      A_CLKSEL: rd_word = {16'h0, rate_q, src_q};
      A_ENABLE: rd_word = {31'h0, en_q};
      A_STATUS: rd_word = {16'h0, rate_v, 7'h0, cur_v};
      A_EXTST:  rd_word = ext_word;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (is_cas)
        rsp_data_o <= owner;
      else if (is_rd)
        rsp_data_o <= {32'h0, rd_word};
      else
        rsp_data_o <= '0;
    end
  end

  assign clk_src_o   = src_q;
  assign clk_rate_o  = rate_q;
  assign stream_en_o = en_q;

  // R12: every request is answered on the next cycle
  a_r12_resp: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> rsp_valid_o);

  // R3: bus reset stops streaming
  a_r3_stream_off: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> !stream_en_o);

  // R7: an out-of-range clock select write changes nothing
  a_r7_reject: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && !sel_ok) |=> ($stable(clk_src_o) && $stable(clk_rate_o)));

  // R7: the accept marker lands in the event register
  a_r7_accept_note: assert property (@(posedge clk) disable iff (rst)
    accept_q |=> note[EV_CLKOK]);
endmodule

// File: tb/audio_glob_regs_test.sv
module audio_glob_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = '0;
  logic [3:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [63:0] req_cmp_i = '0;
  logic [63:0] req_swap_i = '0;
  logic        rsp_valid_o;
  logic [63:0] rsp_data_o;
  logic [1:0]  cfg_chg_i = '0;
  logic [10:0] src_lock_i = '0;
  logic [10:0] src_slip_i = '0;
  logic        cur_lock_i = 1'b0;
  logic [7:0]  nom_rate_i = '0;
  logic [7:0]  clk_src_o, clk_rate_o;
  logic        stream_en_o, ntf_valid_o;
  logic        ntf_ready_i = 1'b0;
  logic [63:0] ntf_addr_o;
  logic [31:0] ntf_word_o;

  localparam logic [63:0] FREE = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] ME   = 64'h0123_0000_4000_0010;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  audio_glob_regs uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input logic [1:0] op, input logic [3:0] a, input logic [31:0] wd,
                     input logic [63:0] c, input logic [63:0] s, output logic [63:0] rd);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a;
    req_wdata_i = wd; req_cmp_i = c; req_swap_i = s;
    @(negedge clk);
    req_valid_i = 1'b0;
    rd = rsp_data_o;
  endtask

  task automatic rd32(input logic [3:0] a, output logic [63:0] rd);
    req(2'd0, a, 32'h0, 64'h0, 64'h0, rd);
  endtask

  task automatic wr32(input logic [3:0] a, input logic [31:0] d);
    logic [63:0] dummy;
    req(2'd1, a, d, 64'h0, 64'h0, dummy);
  endtask

  task automatic consume();
    @(negedge clk); ntf_ready_i = 1'b1;
    @(negedge clk); ntf_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R12 idle rsp_valid", {63'h0, rsp_valid_o}, 64'h0);
    rd32(4'd0, d); chk("R1 owner hi at reset", d, 64'hFFFF0000);
    chk("R12 rsp_valid after read", {63'h0, rsp_valid_o}, 64'h1);
    rd32(4'd1, d); chk("R1 owner lo at reset", d, 64'h0);
    rd32(4'd3, d); chk("R7 clock select reset", d, 64'h020C);
    rd32(4'd4, d); chk("R8 enable at reset", d, 64'h0);
    chk("R6 no request at reset", {63'h0, ntf_valid_o}, 64'h0);
  endtask

  task automatic t_owner_write();
    logic [63:0] d;
    wr32(4'd0, 32'h12345678);
    wr32(4'd1, 32'h9ABCDEF0);
    rd32(4'd0, d); chk("R1 write to owner hi ignored", d, 64'hFFFF0000);
    rd32(4'd1, d); chk("R1 write to owner lo ignored", d, 64'h0);
  endtask

  task automatic t_unowned_event();
    logic [63:0] d;
    @(negedge clk); src_lock_i[3] = 1'b1;
    tick(2);
    chk("R6 no request while unowned", {63'h0, ntf_valid_o}, 64'h0);
    rd32(4'd2, d); chk("R10 lock change sets bit 6", d, 64'h40);
    rd32(4'd6, d); chk("R10 lock bit 3 visible", d, 64'h8);
  endtask

  task automatic t_cas();
    logic [63:0] d;
    req(2'd2, 4'd0, 32'h0, 64'h0, ME, d);
    chk("R2 failed cas returns old", d, FREE);
    rd32(4'd0, d); chk("R2 failed cas leaves owner", d, 64'hFFFF0000);
    req(2'd2, 4'd0, 32'h0, FREE, ME, d);
    chk("R2 claim returns old", d, FREE);
    rd32(4'd0, d); chk("R2 owner hi after claim", d, {32'h0, ME[63:32]});
    rd32(4'd1, d); chk("R2 owner lo after claim", d, {32'h0, ME[31:0]});
    req(2'd2, 4'd0, 32'h0, FREE, 64'h5, d);
    chk("R2 stale compare returns current", d, ME);
  endtask

  task automatic t_deliver();
    logic [63:0] d;
    @(negedge clk); cfg_chg_i = 2'b01;
    @(negedge clk); cfg_chg_i = 2'b00;
    chk("R5 request raised", {63'h0, ntf_valid_o}, 64'h1);
    chk("R5 word is rx config", {32'h0, ntf_word_o}, 64'h1);
    chk("R5 address is owner", ntf_addr_o, ME);
    @(negedge clk); cfg_chg_i = 2'b10;
    @(negedge clk); cfg_chg_i = 2'b00;
    chk("R5 word held while pending", {32'h0, ntf_word_o}, 64'h1);
    rd32(4'd2, d); chk("R4 register holds only new bits", d, 64'h2);
    consume();
    chk("R5 merged request follows", {63'h0, ntf_valid_o}, 64'h1);
    chk("R5 merged word", {32'h0, ntf_word_o}, 64'h2);
    consume();
    chk("R5 request drops after accept", {63'h0, ntf_valid_o}, 64'h0);
  endtask

  task automatic t_clksel();
    logic [63:0] d;
    wr32(4'd3, 32'h0405);
    tick(1);
    chk("R7 accept request", {63'h0, ntf_valid_o}, 64'h1);
    chk("R7 accept bit 5", {32'h0, ntf_word_o}, 64'h20);
    rd32(4'd3, d); chk("R7 new select", d, 64'h0405);
    chk("R7 src output", {56'h0, clk_src_o}, 64'h5);
    consume();
    wr32(4'd3, 32'h000D);
    tick(1);
    chk("R7 rejected write still accepted event", {32'h0, ntf_word_o}, 64'h20);
    rd32(4'd3, d); chk("R7 source 13 ignored", d, 64'h0405);
    consume();
    wr32(4'd3, 32'h0B00);
    rd32(4'd3, d); chk("R7 rate 11 ignored", d, 64'h0405);
    consume();
  endtask

  task automatic t_status();
    logic [63:0] d;
    @(negedge clk); cur_lock_i = 1'b1; nom_rate_i = 8'h04;
    @(negedge clk);
    chk("R4 current lock change bit 4", {32'h0, ntf_word_o}, 64'h10);
    rd32(4'd5, d); chk("R9 status word", d, 64'h0401);
    consume();
    wr32(4'd5, 32'h0);
    rd32(4'd5, d); chk("R9 status write ignored", d, 64'h0401);
  endtask

  task automatic t_enable();
    logic [63:0] d;
    wr32(4'd4, 32'h5);
    chk("R8 nonzero write enables", {63'h0, stream_en_o}, 64'h1);
    rd32(4'd4, d); chk("R8 enable readback", d, 64'h1);
    wr32(4'd4, 32'h0);
    chk("R8 zero write disables", {63'h0, stream_en_o}, 64'h0);
  endtask

  task automatic t_slip();
    logic [63:0] d;
    @(negedge clk); src_slip_i[2] = 1'b1;
    @(negedge clk); src_slip_i[2] = 1'b0;
    tick(2);
    chk("R11 slip raises no request", {63'h0, ntf_valid_o}, 64'h0);
    rd32(4'd6, d); chk("R11 slip flag set", d, 64'h40008);
    rd32(4'd6, d); chk("R11 slip cleared by read", d, 64'h8);
  endtask

  task automatic t_busrst();
    logic [63:0] d;
    wr32(4'd4, 32'h1);
    @(negedge clk); cfg_chg_i = 2'b01;
    @(negedge clk); cfg_chg_i = 2'b00;
    chk("R3 request pending before reset", {63'h0, ntf_valid_o}, 64'h1);
    @(negedge clk); bus_reset_i = 1'b1;
    @(negedge clk); bus_reset_i = 1'b0;
    chk("R3 pending request dropped", {63'h0, ntf_valid_o}, 64'h0);
    chk("R3 streaming stopped", {63'h0, stream_en_o}, 64'h0);
    rd32(4'd0, d); chk("R3 owner released hi", d, 64'hFFFF0000);
    rd32(4'd1, d); chk("R3 owner released lo", d, 64'h0);
  endtask

  task automatic t_unmapped();
    logic [63:0] d;
    rd32(4'd9, d); chk("R12 unmapped read zero", d, 64'h0);
    chk("R12 response strobe", {63'h0, rsp_valid_o}, 64'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_owner_write();
    t_unowned_event();
    t_cas();
    t_deliver();
    t_clksel();
    t_status();
    t_enable();
    t_slip();
    t_busrst();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule